// File: doc/BRIEF.md
# Coherent Sampling Decimator

A coherent-sampling random source captures one clock with a flip-flop driven by a second clock whose frequency is a rational multiple of the first. The two frequencies are in the ratio KM/KD, with both factors integers. Because of that ratio, the captured stream repeats a deterministic pattern every KD sampling periods. This block runs in the sampling clock domain. It XOR-folds each run of KD consecutive captured samples into one output bit. Since every group covers exactly one period of the beat pattern, the deterministic part cancels and only the jitter-driven variation remains. The output bit rate is the sampling frequency divided by KD.

The raw capture arrives asynchronously to the logic, so it first passes through a short flip-flop chain. A small state machine then groups the samples. It starts in `ST_FILL` while the chain fills after reset. It then alternates between `ST_GATHER`, which folds every sample except the last of a group, and `ST_CLOSE`, which folds the last sample, publishes the bit and clears the accumulator. Transitions: `ST_FILL` to `ST_GATHER`, or to `ST_CLOSE` when the group length is one, once the chain is full. `ST_GATHER` to `ST_CLOSE` when the next sample ends the group. `ST_CLOSE` to `ST_GATHER`, or back to `ST_CLOSE` when the newly loaded length is one. The group length is read from its configuration input only during reset and in `ST_CLOSE`. For correct cancellation, the value supplied should be odd and co-prime with the multiplication factor. The block does not check this.

Top module: `cs_decimator`

## Requirements
- R1: Each published bit equals the XOR of KD consecutive synchronized samples. Groups follow one another with no sample dropped or used twice.
- R2: `dec_valid` is high for exactly one cycle, after the clock edge that takes the KD-th sample of a group. It is high in two consecutive cycles only when the group length is 1.
- R3: The accumulator is cleared at the start of every group, so a group's bit does not depend on any earlier sample.
- R4: The group length is taken from `kd_cfg` only at reset edges and at the edge that takes a group's last sample. A change of `kd_cfg` at any other time does not alter the current group.
- R5: A `kd_cfg` value of 0 acts as 1: every synchronized sample is published as its own bit.
- R6: While `rst` is high at a clock edge, `dec_valid` and `dec_bit` become 0, the accumulator is cleared and the machine enters `ST_FILL`.
- R7: `raw_in` passes through two flip-flop stages. The value sampled at the k-th edge after reset is folded at edge k+2, so the first two edges after reset fold nothing.
- R8: A raw stream that is periodic with period KD yields the same output bit for every group, equal to the parity of one period.
- R9: `dec_bit` holds its value in every cycle where `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | 1 | Raw captured bit, asynchronous to clk |
| kd_cfg | input | KD_W | Group length; 0 is treated as 1 |
| dec_bit | output | 1 | Decimated output bit |
| dec_valid | output | 1 | One-cycle strobe marking a new dec_bit |

## Verification
The bound checker watches on every cycle that a strobe only follows a closing edge, that back-to-back strobes occur only with a group length of one, and that the stored length never reads zero. It also checks that the stored length changes only at reset or after a close, that reset leaves the machine filling with no strobe, and that the output bit stays stable between strobes. The data itself can only be checked by the bench's reference model: correct XOR folding across group boundaries, the two-edge synchronizer latency, the accumulator clearing, and constant output for a periodic stream.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_GATHER = 2'd1,
        ST_CLOSE  = 2'd2
    } grp_state_t;

    localparam int SYNC_STAGES_DEFAULT = 2;
    localparam int KD_W_DEFAULT        = 8;

endpackage

// File: rtl/cs_sync_chain.sv
module cs_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/cs_group_fsm.sv
module cs_group_fsm
    import cs_dec_pkg::*;
#(
    parameter int KD_W   = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [KD_W-1:0] kd_cfg,
    output grp_state_t      state_o,
    output logic [KD_W-1:0] kd_o,
    output logic            take_o,
    output logic            close_o
);
    localparam int FILL_W = $clog2(STAGES + 1);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(STAGES - 1);
    localparam logic [KD_W-1:0]   KD_ONE    = KD_W'(1);
    localparam logic [KD_W-1:0]   KD_TWO    = KD_W'(2);

    grp_state_t        state, state_nx;
    logic [KD_W-1:0]   kd_q;
    logic [KD_W-1:0]   kd_norm;
    logic [KD_W-1:0]   cnt;
    logic [FILL_W-1:0] fill_cnt;
    logic              fill_done;
    logic              last_gather;

    // zero length is folded to one
    always_comb begin
        kd_norm = (kd_cfg == '0) ? KD_ONE : kd_cfg;
    end

    assign fill_done   = (fill_cnt == FILL_LAST);
    assign last_gather = (cnt == (kd_q - KD_TWO));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_FILL;
        else     state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL: begin
                if (fill_done)
                    state_nx = (kd_q == KD_ONE) ? ST_CLOSE : ST_GATHER;
            end
            ST_GATHER: begin
                if (last_gather)
                    state_nx = ST_CLOSE;
            end
            ST_CLOSE: begin
                state_nx = (kd_norm == KD_ONE) ? ST_CLOSE : ST_GATHER;
            end
            default: state_nx = ST_FILL;
        endcase
    end

    // group length: loaded at reset and on a closing edge only
    always_ff @(posedge clk) begin
        if (rst)                    kd_q <= kd_norm;
        else if (state == ST_CLOSE) kd_q <= kd_norm;
    end

    // position within the group
    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (state == ST_GATHER) cnt <= cnt + KD_ONE;
        else                         cnt <= '0;
    end

    // synchronizer fill counter
    always_ff @(posedge clk) begin
        if (rst)
            fill_cnt <= '0;
        else if (state == ST_FILL && !fill_done)
            fill_cnt <= fill_cnt + FILL_W'(1);
    end

    // outputs
    always_comb begin
        take_o  = 1'b0;
        close_o = 1'b0;
        unique case (state)
            ST_FILL:   begin take_o = 1'b0; close_o = 1'b0; end
            ST_GATHER: begin take_o = 1'b1; close_o = 1'b0; end
            ST_CLOSE:  begin take_o = 1'b1; close_o = 1'b1; end
            default:   begin take_o = 1'b0; close_o = 1'b0; end
        endcase
    end

    assign state_o = state;
    assign kd_o    = kd_q;

endmodule

// File: rtl/cs_xor_acc.sv
module cs_xor_acc (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic close,
    input  logic sample,
    output logic bit_o,
    output logic valid_o
);
    logic acc;

    always_ff @(posedge clk) begin
        if (rst)        acc <= 1'b0;
        else if (close) acc <= 1'b0;
        else if (take)  acc <= acc ^ sample;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_o   <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= close;
            if (close) bit_o <= acc ^ sample;
        end
    end

endmodule

// File: rtl/cs_decimator.sv
module cs_decimator
    import cs_dec_pkg::*;
#(
    parameter int KD_W        = KD_W_DEFAULT,
    parameter int SYNC_STAGES = SYNC_STAGES_DEFAULT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            raw_in,
    input  logic [KD_W-1:0] kd_cfg,
    output logic            dec_bit,
    output logic            dec_valid
);
    grp_state_t      st;
    logic [KD_W-1:0] kd_q;
    logic            take;
    logic            close;
    logic            smp;

    cs_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (smp)
    );

    cs_group_fsm #(.KD_W(KD_W), .STAGES(SYNC_STAGES)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .kd_cfg  (kd_cfg),
        .state_o (st),
        .kd_o    (kd_q),
        .take_o  (take),
        .close_o (close)
    );

    cs_xor_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .close   (close),
        .sample  (smp),
        .bit_o   (dec_bit),
        .valid_o (dec_valid)
    );

endmodule

// File: rtl/cs_decimator_chk.sv
module cs_decimator_chk
    import cs_dec_pkg::*;
#(
    parameter int KD_W = 8
) (
    input logic            clk,
    input logic            rst,
    input grp_state_t      state,
    input logic [KD_W-1:0] kd_q,
    input logic            dec_valid,
    input logic            dec_bit
);
    assert_strobe_after_close_R2: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(state) == ST_CLOSE);

    assert_back_to_back_only_len1_R2: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && $past(dec_valid)) |-> $past(kd_q) == KD_W'(1));

    assert_len_never_zero_R5: assert property (@(posedge clk) disable iff (rst)
        kd_q != '0);

    assert_len_loads_at_boundary_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(kd_q) |-> ($past(state) == ST_CLOSE || $past(rst)));

    assert_reset_fills_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == ST_FILL && !dec_valid));

    assert_bit_held_R9: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> $stable(dec_bit));

endmodule

bind cs_decimator cs_decimator_chk #(.KD_W(KD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (st),
    .kd_q      (kd_q),
    .dec_valid (dec_valid),
    .dec_bit   (dec_bit)
);

// File: tb/sim_cs_decimator.sv
module sim_cs_decimator;

    localparam int KD_W = 8;

    logic            clk = 1'b0;
    logic            rst;
    logic            raw_in;
    logic [KD_W-1:0] kd_cfg;
    logic            dec_bit;
    logic            dec_valid;

    int    checks   = 0;
    int    failures = 0;
    string cur_req  = "R6";

    // reference model state
    logic  exp_valid = 1'b0;
    logic  exp_bit   = 1'b0;
    logic  m_acc, p1, p2;
    int    m_cnt, m_kd, m_edges;

    always #10 clk = ~clk;

    cs_decimator #(.KD_W(KD_W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .raw_in    (raw_in),
        .kd_cfg    (kd_cfg),
        .dec_bit   (dec_bit),
        .dec_valid (dec_valid)
    );

    function automatic int norm_len(input logic [KD_W-1:0] k);
        return (k == '0) ? 1 : int'(k);
    endfunction

    // advance the model for the coming clock edge
    function automatic void model_edge(input logic r, input logic x, input logic [KD_W-1:0] k);
        logic b;
        if (r) begin
            m_kd = norm_len(k); m_acc = 1'b0; m_cnt = 0; m_edges = 0;
            p1 = 1'b0; p2 = 1'b0; exp_valid = 1'b0; exp_bit = 1'b0;
        end else begin
            m_edges++;
            exp_valid = 1'b0;
            if (m_edges >= 3) begin
                b = p2;
                m_acc ^= b;
                m_cnt++;
                if (m_cnt == m_kd) begin
                    exp_valid = 1'b1; exp_bit = m_acc;
                    m_acc = 1'b0; m_cnt = 0; m_kd = norm_len(k);
                end
            end
            p2 = p1; p1 = x;
        end
    endfunction

    task automatic check_outputs();
        checks++;
        if (dec_valid !== exp_valid) begin
            failures++;
            $display("FAIL %s dec_valid actual=%b expected=%b t=%0t", cur_req, dec_valid, exp_valid, $time);
        end
        checks++;
        if (dec_bit !== exp_bit) begin
            failures++;
            $display("FAIL %s dec_bit actual=%b expected=%b t=%0t", cur_req, dec_bit, exp_bit, $time);
        end
    endtask

    task automatic step(input logic r, input logic x, input logic [KD_W-1:0] k);
        check_outputs();
        rst = r; raw_in = x; kd_cfg = k;
        model_edge(r, x, k);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [KD_W-1:0] k);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, k);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [6:0] pat;
        int ones;
        void'($urandom(32'd20250611));
        rst = 1'b1; raw_in = 1'b0; kd_cfg = 8'd5;
        model_edge(1'b1, 1'b0, 8'd5);
        @(negedge clk);

        // R6: reset state
        cur_req = "R6";
        do_reset(8'd5);

        // R7: latency with length 1, distinct pattern
        cur_req = "R7";
        do_reset(8'd1);
        for (int i = 0; i < 40; i++) step(1'b0, 1'((i * 7 + 3) % 5 > 1), 8'd1);

        // R5: zero length passes each sample through
        cur_req = "R5";
        do_reset(8'd0);
        for (int i = 0; i < 60; i++) step(1'b0, 1'($urandom), 8'd0);

        // R1: random stream, fixed odd length
        cur_req = "R1";
        do_reset(8'd5);
        for (int i = 0; i < 400; i++) step(1'b0, 1'($urandom), 8'd5);

        // R3: all-ones stream, length 3, every group independent
        cur_req = "R3";
        do_reset(8'd3);
        for (int i = 0; i < 90; i++) step(1'b0, 1'b1, 8'd3);

        // R8: stream periodic with the group length
        cur_req = "R8";
        pat = 7'b1011001;
        ones = $countones(pat);
        do_reset(8'd7);
        for (int i = 0; i < 7 * 30; i++) step(1'b0, pat[i % 7], 8'd7);
        checks++;
        if (exp_bit !== 1'(ones % 2) || dec_bit !== 1'(ones % 2)) begin
            failures++;
            $display("FAIL R8 period parity actual=%b expected=%b", dec_bit, 1'(ones % 2));
        end

        // R4: length changes every cycle, only boundaries take effect
        cur_req = "R4";
        do_reset(8'd9);
        for (int i = 0; i < 1500; i++)
            step(1'b0, 1'($urandom), KD_W'(($urandom % 13) | 1));

        // R2: mixed lengths including 1, 0 and a long group
        cur_req = "R2";
        do_reset(8'd255);
        for (int i = 0; i < 700; i++) step(1'b0, 1'($urandom), 8'd255);
        for (int i = 0; i < 600; i++)
            step(1'b0, 1'($urandom), KD_W'($urandom % 4));

        // R9: random stream with mid-run reset, bit must hold between strobes
        cur_req = "R9";
        for (int i = 0; i < 300; i++) begin
            if (i == 150) do_reset(8'd11);
            step(1'b0, 1'($urandom), 8'd11);
        end

        check_outputs();
        finish_run();
    end

endmodule